// File: doc/BRIEF.md
# Supervisor Call Execution Unit

This unit receives one fetched 32-bit instruction word per cycle, together with the address the word was fetched from, a valid strobe and the current machine state word. It checks whether the word is a supervisor call. When it is, the unit computes where fetch must resume. It also computes the values that the count register, the link register and the machine state register take when the call is taken. Every result appears on registered outputs one cycle after the valid input. The surrounding pipeline applies them.

Bits are numbered with bit 0 as the most significant bit, so instruction bit k is `insn_i[31-k]`. The resume address is a base address plus an offset. The base is selected by one bit of the machine state word. The offset is either one of 128 handler slots, 32 bytes apart and picked by a 7-bit level field, or a single fixed absolute slot. Fields that only carry data for software are copied into the count register and have no other effect. Words with a different primary opcode raise a one-cycle illegal pulse and cause no writes.

Top module: `svcall_unit`

## Requirements
- R1: When `valid_i` is high and instruction bits 0-5 (`insn_i[31:26]`) equal 17, the next cycle has `redirect_o`, `cnt_we_o` and `mst_we_o` high and `illegal_o` low. Reserved bits 6-15 have no effect.
- R2: When `valid_i` is high and the opcode is not 17, the next cycle has `illegal_o` high and `redirect_o`, `cnt_we_o`, `link_we_o` and `mst_we_o` all low.
- R3: When `valid_i` is low, the next cycle has all five strobes (`redirect_o`, `cnt_we_o`, `link_we_o`, `mst_we_o`, `illegal_o`) low.
- R4: When the absolute flag (bit 30, `insn_i[1]`) is 0, `target_o` = base + 0x1000 + 32 × level. The level is bits 20-26 (`insn_i[11:5]`), so levels 0 and 127 give offsets 0x1000 and 0x1FE0.
- R5: When the absolute flag is 1, `target_o` = base + 0x1FE0 for any level.
- R6: The base is 0x00000000 when the vector-select bit of `mst_i` (bit 25, `mst_i[6]`) is 0, and 0xFFF00000 when that bit is 1.
- R7: When the link flag (bit 31, `insn_i[0]`) is 1, `link_we_o` is high and `link_o` = `pc_i` + 4. When the flag is 0, `link_we_o` is low.
- R8: `cnt_o` = {`insn_i[15:0]`, `mst_i[15:0]`}. This is instruction bits 16-31 followed by state bits 16-31, and the state half is taken before any bit is cleared.
- R9: `mst_o` equals `mst_i` with bits 16, 17 and 20 (`mst_i[15]`, `mst_i[14]`, `mst_i[11]`) forced to 0. Every other bit, the vector-select bit included, is unchanged.
- R10: The software data fields (bits 16-19 and 27-29) change nothing except `cnt_o`.
- R11: While `rst_ni` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | Instruction word is valid this cycle |
| insn_i | input | 32 | Fetched instruction word |
| pc_i | input | 32 | Address of the instruction |
| mst_i | input | 32 | Current machine state word |
| redirect_o | output | 1 | Fetch redirect request |
| target_o | output | 32 | Redirect address |
| cnt_we_o | output | 1 | Count register write enable |
| cnt_o | output | 32 | Count register write data |
| link_we_o | output | 1 | Link register write enable |
| link_o | output | 32 | Link register write data |
| mst_we_o | output | 1 | Machine state write enable |
| mst_o | output | 32 | Machine state write data |
| illegal_o | output | 1 | Word was valid but not a supervisor call |

## Verification
The bench builds the unit with its default parameters: 32-bit words, the stated bit positions and a high base of 0xFFF00000. With these values the offset span has no bits in common with either base, so the generate step picks the OR-merge variant of the target path. Under this configuration every combination of absolute flag, link flag, vector-select bit and level (1024 cases) is cheap to sweep in full. Each case also varies the reserved and software fields, so the sweep shows both the exact offset arithmetic and the absence of any effect from those fields. All 63 other opcodes are then applied to cover the illegal path.

// File: rtl/svcall_pkg.sv
package svcall_pkg;

   localparam int unsigned INSN_W  = 32;
   localparam int unsigned LEVEL_W = 7;

   // Instruction layout, most significant field first
   typedef struct packed {
      logic [5:0]         opc;
      logic [9:0]         rsvd;
      logic [3:0]         sw_a;
      logic [LEVEL_W-1:0] level;
      logic [2:0]         sw_b;
      logic               absolute;
      logic               link;
   } svc_insn_t;

   // Convert an MSB-first bit number into a vector index
   function automatic int unsigned msb_idx(input int unsigned pos, input int unsigned w);
      return w - 1 - pos;
   endfunction

endpackage

// File: rtl/svcall_decode.sv
module svcall_decode
   import svcall_pkg::*;
#(
   parameter int unsigned OPCODE = 17
) (
   input  logic                valid_i,
   input  logic [INSN_W-1:0]   insn_i,
   output logic [LEVEL_W-1:0]  level_o,
   output logic                absolute_o,
   output logic                link_o,
   output logic                hit_o,
   output logic                miss_o
);

   svc_insn_t f;
   logic      opc_match;
   logic      unused_fields;

   assign f             = svc_insn_t'(insn_i);
   assign opc_match     = (f.opc == 6'(OPCODE));
   assign hit_o         = valid_i &  opc_match;
   assign miss_o        = valid_i & ~opc_match;
   assign level_o       = f.level;
   assign absolute_o    = f.absolute;
   assign link_o        = f.link;
   assign unused_fields = ^{f.rsvd, f.sw_a, f.sw_b};

endmodule

// File: rtl/svcall_target.sv
module svcall_target
   import svcall_pkg::*;
#(
   parameter int unsigned ADDR_W     = 32,
   parameter logic [31:0] BASE_LO    = 32'h0000_0000,
   parameter logic [31:0] BASE_HI    = 32'hFFF0_0000,
   parameter int unsigned SLOT_SHIFT = 5,
   parameter logic [31:0] ABS_OFS    = 32'h0000_1FE0
) (
   input  logic [LEVEL_W-1:0] level_i,
   input  logic               absolute_i,
   input  logic               vec_sel_i,
   output logic [ADDR_W-1:0]  target_o
);

   localparam int unsigned OFS_W    = SLOT_SHIFT + LEVEL_W + 1;
   localparam logic [31:0] OFS_MASK = (32'd1 << OFS_W) - 32'd1;
   localparam bit          USE_OR   = (((BASE_LO | BASE_HI) & OFS_MASK) == 32'd0);

   if (OFS_W >= ADDR_W) begin : g_bad_width
      $error("svcall_target: offset span does not fit the address width");
   end
   if ((ABS_OFS & ~OFS_MASK) != 32'd0) begin : g_bad_abs
      $error("svcall_target: absolute offset exceeds the offset span");
   end

   logic [OFS_W-1:0]  slot_ofs;
   logic [OFS_W-1:0]  ofs;
   logic [ADDR_W-1:0] ofs_ext;
   logic [ADDR_W-1:0] base;

   assign slot_ofs = {1'b1, level_i, {SLOT_SHIFT{1'b0}}};
   assign ofs      = absolute_i ? ABS_OFS[OFS_W-1:0] : slot_ofs;
   assign ofs_ext  = {{(ADDR_W-OFS_W){1'b0}}, ofs};
   assign base     = vec_sel_i ? BASE_HI[ADDR_W-1:0] : BASE_LO[ADDR_W-1:0];

   if (USE_OR) begin : g_merge_or
      assign target_o = base | ofs_ext;
   end else begin : g_merge_add
      assign target_o = base + ofs_ext;
   end

endmodule

// File: rtl/svcall_state.sv
module svcall_state
   import svcall_pkg::*;
#(
   parameter int unsigned XLEN   = 32,
   parameter int unsigned POS_EE = 16,
   parameter int unsigned POS_PR = 17,
   parameter int unsigned POS_FE = 20
) (
   input  logic [XLEN/2-1:0] insn_lo_i,
   input  logic [XLEN-1:0]   mst_i,
   output logic [XLEN-1:0]   cnt_o,
   output logic [XLEN-1:0]   mst_o
);

   localparam int unsigned HALF = XLEN / 2;

   function automatic logic [XLEN-1:0] clear_mask();
      logic [XLEN-1:0] m;
      m = '0;
      m[msb_idx(POS_EE, XLEN)] = 1'b1;
      m[msb_idx(POS_PR, XLEN)] = 1'b1;
      m[msb_idx(POS_FE, XLEN)] = 1'b1;
      return m;
   endfunction

   localparam logic [XLEN-1:0] CLR = clear_mask();

   assign cnt_o = {insn_lo_i, mst_i[HALF-1:0]};
   assign mst_o = mst_i & ~CLR;

endmodule

// File: rtl/svcall_unit.sv
module svcall_unit
   import svcall_pkg::*;
#(
   parameter int unsigned XLEN    = 32,
   parameter int unsigned OPCODE  = 17,
   parameter int unsigned POS_EE  = 16,
   parameter int unsigned POS_PR  = 17,
   parameter int unsigned POS_FE  = 20,
   parameter int unsigned POS_VEC = 25,
   parameter logic [31:0] BASE_LO = 32'h0000_0000,
   parameter logic [31:0] BASE_HI = 32'hFFF0_0000
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic            valid_i,
   input  logic [31:0]     insn_i,
   input  logic [XLEN-1:0] pc_i,
   input  logic [XLEN-1:0] mst_i,
   output logic            redirect_o,
   output logic [XLEN-1:0] target_o,
   output logic            cnt_we_o,
   output logic [XLEN-1:0] cnt_o,
   output logic            link_we_o,
   output logic [XLEN-1:0] link_o,
   output logic            mst_we_o,
   output logic [XLEN-1:0] mst_o,
   output logic            illegal_o
);

   localparam int unsigned IDX_VEC  = msb_idx(POS_VEC, XLEN);
   localparam logic [XLEN-1:0] STEP = XLEN'(INSN_W / 8);

   if (XLEN != INSN_W) begin : g_bad_xlen
      $error("svcall_unit: XLEN must equal the instruction width");
   end
   if (OPCODE > 63) begin : g_bad_opc
      $error("svcall_unit: OPCODE does not fit six bits");
   end
   if (POS_EE >= XLEN || POS_PR >= XLEN || POS_FE >= XLEN || POS_VEC >= XLEN) begin : g_bad_pos
      $error("svcall_unit: state bit position out of range");
   end
   if (POS_EE == POS_PR || POS_EE == POS_FE || POS_PR == POS_FE ||
       POS_VEC == POS_EE || POS_VEC == POS_PR || POS_VEC == POS_FE) begin : g_dup_pos
      $error("svcall_unit: state bit positions must be distinct");
   end

   logic [LEVEL_W-1:0] level;
   logic               absolute;
   logic               link_flag;
   logic               hit;
   logic               miss;
   logic [XLEN-1:0]    target_d;
   logic [XLEN-1:0]    cnt_d;
   logic [XLEN-1:0]    mst_d;

   svcall_decode #(.OPCODE(OPCODE)) u_decode (
      .valid_i    (valid_i),
      .insn_i     (insn_i),
      .level_o    (level),
      .absolute_o (absolute),
      .link_o     (link_flag),
      .hit_o      (hit),
      .miss_o     (miss)
   );

   svcall_target #(
      .ADDR_W  (XLEN),
      .BASE_LO (BASE_LO),
      .BASE_HI (BASE_HI)
   ) u_target (
      .level_i    (level),
      .absolute_i (absolute),
      .vec_sel_i  (mst_i[IDX_VEC]),
      .target_o   (target_d)
   );

   svcall_state #(
      .XLEN   (XLEN),
      .POS_EE (POS_EE),
      .POS_PR (POS_PR),
      .POS_FE (POS_FE)
   ) u_state (
      .insn_lo_i (insn_i[XLEN/2-1:0]),
      .mst_i     (mst_i),
      .cnt_o     (cnt_d),
      .mst_o     (mst_d)
   );

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         redirect_o <= 1'b0;
         cnt_we_o   <= 1'b0;
         link_we_o  <= 1'b0;
         mst_we_o   <= 1'b0;
         illegal_o  <= 1'b0;
         target_o   <= '0;
         cnt_o      <= '0;
         link_o     <= '0;
         mst_o      <= '0;
      end else begin
         redirect_o <= hit;
         cnt_we_o   <= hit;
         link_we_o  <= hit & link_flag;
         mst_we_o   <= hit;
         illegal_o  <= miss;
         if (hit) begin
            target_o <= target_d;
            cnt_o    <= cnt_d;
            link_o   <= pc_i + STEP;
            mst_o    <= mst_d;
         end
      end
   end

endmodule

// File: rtl/svcall_unit_chk.sv
module svcall_unit_chk #(
   parameter int unsigned XLEN    = 32,
   parameter int unsigned OPCODE  = 17,
   parameter int unsigned POS_EE  = 16,
   parameter int unsigned POS_PR  = 17,
   parameter int unsigned POS_FE  = 20,
   parameter int unsigned POS_VEC = 25
) (
   input logic            clk_i,
   input logic            rst_ni,
   input logic            valid_i,
   input logic [31:0]     insn_i,
   input logic [XLEN-1:0] pc_i,
   input logic [XLEN-1:0] mst_i,
   input logic            redirect_o,
   input logic [XLEN-1:0] target_o,
   input logic            cnt_we_o,
   input logic [XLEN-1:0] cnt_o,
   input logic            link_we_o,
   input logic [XLEN-1:0] link_o,
   input logic            mst_we_o,
   input logic [XLEN-1:0] mst_o,
   input logic            illegal_o
);

   localparam int unsigned I_EE  = XLEN - 1 - POS_EE;
   localparam int unsigned I_PR  = XLEN - 1 - POS_PR;
   localparam int unsigned I_FE  = XLEN - 1 - POS_FE;
   localparam int unsigned I_VEC = XLEN - 1 - POS_VEC;

   a_r1_call_strobes: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && insn_i[31:26] == 6'(OPCODE)) |=> (redirect_o && cnt_we_o && mst_we_o && !illegal_o));

   a_r2_other_opcode: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && insn_i[31:26] != 6'(OPCODE)) |=>
         (illegal_o && !redirect_o && !cnt_we_o && !link_we_o && !mst_we_o));

   a_r3_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_i |=> !(redirect_o || cnt_we_o || link_we_o || mst_we_o || illegal_o));

   a_r4_slot_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
      redirect_o |-> (target_o[4:0] == 5'd0 && target_o[12]));

   a_r7_link_needs_call: assert property (@(posedge clk_i) disable iff (!rst_ni)
      link_we_o |-> (redirect_o && link_o == $past(pc_i) + XLEN'(4)));

   a_r9_bits_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mst_we_o |-> (!mst_o[I_EE] && !mst_o[I_PR] && !mst_o[I_FE]));

   a_r9_vec_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && insn_i[31:26] == 6'(OPCODE)) |=> (mst_o[I_VEC] == $past(mst_i[I_VEC])));

   a_r8_count_state_half: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && insn_i[31:26] == 6'(OPCODE)) |=> (cnt_o[XLEN/2-1:0] == $past(mst_i[XLEN/2-1:0])));

endmodule

bind svcall_unit svcall_unit_chk #(
   .XLEN    (XLEN),
   .OPCODE  (OPCODE),
   .POS_EE  (POS_EE),
   .POS_PR  (POS_PR),
   .POS_FE  (POS_FE),
   .POS_VEC (POS_VEC)
) u_svcall_unit_chk (.*);

// File: tb/test_svcall_unit.sv
module test_svcall_unit;

   logic        clk_i = 1'b0;
   logic        rst_ni = 1'b0;
   logic        valid_i = 1'b0;
   logic [31:0] insn_i = '0;
   logic [31:0] pc_i = '0;
   logic [31:0] mst_i = '0;
   logic        redirect_o, cnt_we_o, link_we_o, mst_we_o, illegal_o;
   logic [31:0] target_o, cnt_o, link_o, mst_o;

   int unsigned errors = 0;
   int unsigned checks = 0;
   bit          done = 1'b0;
   logic [31:0] seed = 32'h1234_5678;

   always #2 clk_i = ~clk_i;

   svcall_unit i_svcall_unit (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .valid_i    (valid_i),
      .insn_i     (insn_i),
      .pc_i       (pc_i),
      .mst_i      (mst_i),
      .redirect_o (redirect_o),
      .target_o   (target_o),
      .cnt_we_o   (cnt_we_o),
      .cnt_o      (cnt_o),
      .link_we_o  (link_we_o),
      .link_o     (link_o),
      .mst_we_o   (mst_we_o),
      .mst_o      (mst_o),
      .illegal_o  (illegal_o)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] next_rand(input logic [31:0] s);
      return s * 32'd1664525 + 32'd1013904223;
   endfunction

   initial begin
      // R11: outputs during reset
      repeat (3) @(negedge clk_i);
      check("R11 strobes", {27'd0, redirect_o, cnt_we_o, link_we_o, mst_we_o, illegal_o}, 32'd0);
      check("R11 data", target_o | cnt_o | link_o | mst_o, 32'd0);
      rst_ni = 1'b1;
      @(negedge clk_i);
      // R3: idle after reset
      check("R3 idle", {27'd0, redirect_o, cnt_we_o, link_we_o, mst_we_o, illegal_o}, 32'd0);

      // Full sweep: vector-select x absolute x link x level
      for (int vs = 0; vs < 2; vs++) begin
         for (int ab = 0; ab < 2; ab++) begin
            for (int lk = 0; lk < 2; lk++) begin
               for (int lv = 0; lv < 128; lv++) begin
                  logic [31:0] r1, r2, pc, ms, ins, base, ofs;
                  seed = next_rand(seed); r1 = seed;
                  seed = next_rand(seed); r2 = seed;
                  pc = {r1[31:2], 2'b00};
                  ms = r2;
                  ms[6] = vs[0];
                  // opcode 17, random reserved and software fields (R10)
                  ins = {6'd17, r1[9:0], r2[3:0], lv[6:0], r2[6:4], ab[0], lk[0]};
                  valid_i = 1'b1; insn_i = ins; pc_i = pc; mst_i = ms;
                  @(negedge clk_i);
                  base = vs[0] ? 32'hFFF0_0000 : 32'h0;
                  ofs  = ab[0] ? 32'h1FE0 : (32'h1000 + 32'(lv) * 32);
                  check("R1 strobes", {29'd0, redirect_o, cnt_we_o, mst_we_o}, 32'd7);
                  check("R1 no illegal", {31'd0, illegal_o}, 32'd0);
                  if (ab[0]) check("R5 R6 R10 target", target_o, base + ofs);
                  else       check("R4 R6 R10 target", target_o, base + ofs);
                  check("R7 link enable", {31'd0, link_we_o}, {31'd0, lk[0]});
                  if (lk[0]) check("R7 link data", link_o, pc + 32'd4);
                  check("R8 count", cnt_o, {ins[15:0], ms[15:0]});
                  check("R9 R10 state", mst_o, ms & ~32'h0000_C800);
               end
            end
         end
      end

      // R2: every other opcode
      for (int op = 0; op < 64; op++) begin
         if (op != 17) begin
            seed = next_rand(seed);
            valid_i = 1'b1;
            insn_i  = {op[5:0], seed[25:0]};
            mst_i   = ~seed;
            @(negedge clk_i);
            check("R2 illegal", {31'd0, illegal_o}, 32'd1);
            check("R2 no writes", {28'd0, redirect_o, cnt_we_o, link_we_o, mst_we_o}, 32'd0);
         end
      end

      // R3: call word presented without valid
      valid_i = 1'b0;
      insn_i  = {6'd17, 24'd0, 2'b11};
      @(negedge clk_i);
      check("R3 no valid", {27'd0, redirect_o, cnt_we_o, link_we_o, mst_we_o, illegal_o}, 32'd0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(4 * 20000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule